// File: doc/BRIEF.md
# Cache-Side Coherence Race Handler

This block is the coherence state keeper for a private cache with a small set of lines. Each line holds one of six states. Three are stable: Invalid, Shared and Modified. Three are transient: a shared copy waiting for upgrade permission, a write miss waiting for a grant, and a dirty line waiting for its writeback to be acknowledged. The core asks to fill, write or evict a line. The block turns those requests into messages to the home directory, takes the directory's acknowledgements, and answers every Invalidate the directory sends.

Coherence transactions are not atomic, so an Invalidate can reach a line while that line's own request is still in flight. Each incoming Invalidate carries the identity of the cache the directory is serving at that moment. If that identity is this cache, its own request was ordered first, and the line keeps waiting with its copy. If it names another cache, the request is being held behind the other one. The local copy is then dropped, and the pending upgrade becomes a write miss that ends in Modified when granted. An Invalidate that meets a line being written back changes nothing, because the writeback already removes the line. Only one request may be outstanding at a time.

Top module: `coh_race_ctl`

## Requirements
- R1: After reset every line reads as Invalid (code 0), busy is 0, and req_valid, grant_valid and inv_ack_valid are 0.
- R2: A fill (cpu_op 0) on an Invalid line makes it Shared (code 1). A fill on a line in any other state is ignored.
- R3: A write (cpu_op 1) on a Shared line moves it to pending-upgrade (code 3). One cycle later it gives a one-cycle req_valid pulse with req_kind 0 and the line, and busy goes to 1.
- R4: A write on an Invalid line moves it to pending-write-miss (code 4) and sends req_kind 1. A write on a Modified line sends no request and pulses grant_valid with the line one cycle later.
- R5: An ack whose ack_line matches the outstanding request's line moves pending-upgrade or pending-write-miss to Modified (code 2). It pulses grant_valid one cycle later and clears busy. An ack with nothing outstanding, or for another line, has no effect.
- R6: An Invalidate on a pending-upgrade line whose inv_owner equals MY_ID leaves the line in pending-upgrade.
- R7: An Invalidate on a pending-upgrade line whose inv_owner differs from MY_ID moves the line to pending-write-miss. The request stays outstanding, and its ack ends in Modified with a grant.
- R8: An evict (cpu_op 2) on a Modified line moves it to pending-writeback (code 5) and sends req_kind 2. The matching ack makes it Invalid without a grant. An evict on a Shared line makes it Invalid with no message.
- R9: An Invalidate leaves a pending-writeback line unchanged. It makes a Shared or Modified line Invalid, and it leaves Invalid and pending-write-miss lines unchanged.
- R10: Every Invalidate is acknowledged exactly once. inv_ack_valid pulses one cycle after inv_valid, carrying the same line.
- R11: A core request is ignored while busy is 1, and in any cycle in which inv_valid is 1.
- R12: rd_state gives, one cycle after rd_line is applied, the state that line had in the cycle rd_line was applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Core request present |
| cpu_op | input | 2 | 0 fill, 1 write, 2 evict, 3 none |
| cpu_line | input | LINE_W | Line the core request targets |
| inv_valid | input | 1 | Invalidate from the directory |
| inv_line | input | LINE_W | Line to invalidate |
| inv_owner | input | ID_W | Cache the directory is currently serving |
| ack_valid | input | 1 | Directory acknowledgement of the outstanding request |
| ack_line | input | LINE_W | Line the acknowledgement refers to |
| rd_line | input | LINE_W | Line whose state is looked up |
| req_valid | output | 1 | Request to the directory, one-cycle pulse |
| req_kind | output | 2 | 0 upgrade, 1 write miss, 2 writeback |
| req_line | output | LINE_W | Line of the request |
| grant_valid | output | 1 | Core may write the line, one-cycle pulse |
| grant_line | output | LINE_W | Line being granted |
| inv_ack_valid | output | 1 | Invalidate acknowledgement pulse |
| inv_ack_line | output | LINE_W | Line being acknowledged |
| busy | output | 1 | A request is outstanding |
| rd_state | output | 3 | State code of the looked-up line |

## Verification
The bench sweeps every line through the full life cycle: fill, upgrade, race, grant, local write, writeback under an Invalidate, and write miss. Even lines see an Invalidate tagged with this cache and odd lines one tagged with another cache, so the won race (line stays pending-upgrade) is told apart from the lost race (line drops to pending-write-miss). Stray acks, for no request or for the wrong line, and core requests issued while busy or alongside an Invalidate separate real state changes from ignored stimulus. Every Invalidate, whatever the line's state, is checked for its single acknowledgement.

// File: rtl/cr_pkg.sv
package cr_pkg;
  typedef enum logic [2:0] {
    LS_I   = 3'd0,
    LS_S   = 3'd1,
    LS_M   = 3'd2,
    LS_PU  = 3'd3,
    LS_PWM = 3'd4,
    LS_PWB = 3'd5
  } line_st_e;

  typedef enum logic [1:0] {
    OP_FILL  = 2'd0,
    OP_WRITE = 2'd1,
    OP_EVICT = 2'd2,
    OP_NONE  = 2'd3
  } cpu_op_e;

  typedef enum logic [1:0] {
    RK_UPG    = 2'd0,
    RK_WRMISS = 2'd1,
    RK_WB     = 2'd2
  } req_kind_e;
endpackage

// File: rtl/cr_line_fsm.sv
module cr_line_fsm
  import cr_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     op_hit,
  input  cpu_op_e  op,
  input  logic     ack_hit,
  input  logic     inv_hit,
  input  logic     inv_mine,
  output line_st_e st
);
  line_st_e after_op, after_ack, nxt;

  always_comb begin
    after_op = st;
    if (op_hit) begin
      unique case (op)
        OP_FILL:  if (st == LS_I) after_op = LS_S;
        OP_WRITE: begin
          if (st == LS_S)      after_op = LS_PU;
          else if (st == LS_I) after_op = LS_PWM;
        end
        OP_EVICT: begin
          if (st == LS_M)      after_op = LS_PWB;
          else if (st == LS_S) after_op = LS_I;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    after_ack = after_op;
    if (ack_hit) begin
      unique case (after_op)
        LS_PU, LS_PWM: after_ack = LS_M;
        LS_PWB:        after_ack = LS_I;
        default: ;
      endcase
    end
  end

  always_comb begin
    nxt = after_ack;
    if (inv_hit) begin
      unique case (after_ack)
        LS_S, LS_M: nxt = LS_I;
        LS_PU:      if (!inv_mine) nxt = LS_PWM;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st <= LS_I;
    else     st <= nxt;
  end

  // R9
  pwb_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (inv_hit && !ack_hit && !op_hit && st == LS_PWB) |=> st == LS_PWB);
  // R7
  lost_race_chk: assert property (@(posedge clk) disable iff (rst)
    (inv_hit && !ack_hit && !op_hit && !inv_mine && st == LS_PU) |=> st == LS_PWM);
  // R6
  won_race_chk: assert property (@(posedge clk) disable iff (rst)
    (inv_hit && !ack_hit && !op_hit && inv_mine && st == LS_PU) |=> st == LS_PU);
  // R1
  legal_state_chk: assert property (@(posedge clk) disable iff (rst)
    st inside {LS_I, LS_S, LS_M, LS_PU, LS_PWM, LS_PWB});
endmodule

// File: rtl/cr_pending.sv
module cr_pending #(
  parameter int LINE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  logic [LINE_W-1:0] issue_line,
  input  logic              ack_in,
  input  logic [LINE_W-1:0] ack_line,
  output logic              pend_valid,
  output logic [LINE_W-1:0] pend_line,
  output logic              ack_match
);
  assign ack_match = ack_in && pend_valid && (ack_line == pend_line);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_valid <= 1'b0;
      pend_line  <= '0;
    end else if (issue) begin
      pend_valid <= 1'b1;
      pend_line  <= issue_line;
    end else if (ack_match) begin
      pend_valid <= 1'b0;
    end
  end

  // R11
  single_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
    issue |-> !pend_valid);
  // R5
  ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
    ack_match |=> !pend_valid);
endmodule

// File: rtl/cr_msg_reg.sv
module cr_msg_reg #(
  parameter int LINE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  logic [1:0]        issue_kind,
  input  logic [LINE_W-1:0] issue_line,
  input  logic              grant,
  input  logic [LINE_W-1:0] grant_in_line,
  input  logic              inv_in,
  input  logic [LINE_W-1:0] inv_in_line,
  input  logic [2:0]        look_state,
  output logic              req_valid,
  output logic [1:0]        req_kind,
  output logic [LINE_W-1:0] req_line,
  output logic              grant_valid,
  output logic [LINE_W-1:0] grant_line,
  output logic              inv_ack_valid,
  output logic [LINE_W-1:0] inv_ack_line,
  output logic [2:0]        rd_state
);
  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid     <= 1'b0;
      req_kind      <= '0;
      req_line      <= '0;
      grant_valid   <= 1'b0;
      grant_line    <= '0;
      inv_ack_valid <= 1'b0;
      inv_ack_line  <= '0;
      rd_state      <= '0;
    end else begin
      req_valid     <= issue;
      if (issue) begin
        req_kind <= issue_kind;
        req_line <= issue_line;
      end
      grant_valid   <= grant;
      if (grant) grant_line <= grant_in_line;
      inv_ack_valid <= inv_in;
      if (inv_in) inv_ack_line <= inv_in_line;
      rd_state      <= look_state;
    end
  end

  // R10
  inv_ack_once_chk: assert property (@(posedge clk) disable iff (rst)
    inv_in |=> (inv_ack_valid && inv_ack_line == $past(inv_in_line)));
  // R10
  no_spurious_ack_chk: assert property (@(posedge clk) disable iff (rst)
    !inv_in |=> !inv_ack_valid);
endmodule

// File: rtl/coh_race_ctl.sv
module coh_race_ctl
  import cr_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int ID_W      = 2,
  parameter int MY_ID     = 1,
  localparam int LINE_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_valid,
  input  logic [1:0]        cpu_op,
  input  logic [LINE_W-1:0] cpu_line,
  input  logic              inv_valid,
  input  logic [LINE_W-1:0] inv_line,
  input  logic [ID_W-1:0]   inv_owner,
  input  logic              ack_valid,
  input  logic [LINE_W-1:0] ack_line,
  input  logic [LINE_W-1:0] rd_line,
  output logic              req_valid,
  output logic [1:0]        req_kind,
  output logic [LINE_W-1:0] req_line,
  output logic              grant_valid,
  output logic [LINE_W-1:0] grant_line,
  output logic              inv_ack_valid,
  output logic [LINE_W-1:0] inv_ack_line,
  output logic              busy,
  output logic [2:0]        rd_state
);
  line_st_e          st [NUM_LINES];
  logic              pend_valid, ack_match;
  logic [LINE_W-1:0] pend_line;
  cpu_op_e           op;
  logic              op_ok, inv_mine;
  line_st_e          cpu_st, pend_st;
  logic              issue, grant;
  req_kind_e         issue_kind;
  logic [LINE_W-1:0] grant_ln;

  assign op       = cpu_op_e'(cpu_op);
  assign op_ok    = cpu_valid && !pend_valid && !inv_valid && (op != OP_NONE);
  assign inv_mine = (inv_owner == ID_W'(MY_ID));
  assign cpu_st   = st[cpu_line];
  assign pend_st  = st[pend_line];

  always_comb begin
    issue      = 1'b0;
    issue_kind = RK_UPG;
    if (op_ok) begin
      if (op == OP_WRITE && cpu_st == LS_S) begin
        issue = 1'b1; issue_kind = RK_UPG;
      end else if (op == OP_WRITE && cpu_st == LS_I) begin
        issue = 1'b1; issue_kind = RK_WRMISS;
      end else if (op == OP_EVICT && cpu_st == LS_M) begin
        issue = 1'b1; issue_kind = RK_WB;
      end
    end
  end

  always_comb begin
    grant    = 1'b0;
    grant_ln = cpu_line;
    if (op_ok && op == OP_WRITE && cpu_st == LS_M) begin
      grant = 1'b1;
    end else if (ack_match && (pend_st == LS_PU || pend_st == LS_PWM)) begin
      grant    = 1'b1;
      grant_ln = pend_line;
    end
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    cr_line_fsm u_fsm (
      .clk      (clk),
      .rst      (rst),
      .op_hit   (op_ok && cpu_line == LINE_W'(i)),
      .op       (op),
      .ack_hit  (ack_match && pend_line == LINE_W'(i)),
      .inv_hit  (inv_valid && inv_line == LINE_W'(i)),
      .inv_mine (inv_mine),
      .st       (st[i])
    );
  end

  cr_pending #(.LINE_W(LINE_W)) u_pend (
    .clk        (clk),
    .rst        (rst),
    .issue      (issue),
    .issue_line (cpu_line),
    .ack_in     (ack_valid),
    .ack_line   (ack_line),
    .pend_valid (pend_valid),
    .pend_line  (pend_line),
    .ack_match  (ack_match)
  );

  cr_msg_reg #(.LINE_W(LINE_W)) u_msg (
    .clk           (clk),
    .rst           (rst),
    .issue         (issue),
    .issue_kind    (issue_kind),
    .issue_line    (cpu_line),
    .grant         (grant),
    .grant_in_line (grant_ln),
    .inv_in        (inv_valid),
    .inv_in_line   (inv_line),
    .look_state    (st[rd_line]),
    .req_valid     (req_valid),
    .req_kind      (req_kind),
    .req_line      (req_line),
    .grant_valid   (grant_valid),
    .grant_line    (grant_line),
    .inv_ack_valid (inv_ack_valid),
    .inv_ack_line  (inv_ack_line),
    .rd_state      (rd_state)
  );

  assign busy = pend_valid;

  // R11
  no_req_when_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !ack_valid) |=> !req_valid);
  // R8
  wb_no_grant_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_match && pend_st == LS_PWB) |=> !grant_valid);
endmodule

// File: tb/coh_race_ctl_bench.sv
module coh_race_ctl_bench;
  localparam int NL = 4;
  localparam int LW = 2;
  localparam int ME = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_valid = 1'b0;
  logic [1:0] cpu_op = 2'd3;
  logic [LW-1:0] cpu_line = '0;
  logic inv_valid = 1'b0;
  logic [LW-1:0] inv_line = '0;
  logic [1:0] inv_owner = '0;
  logic ack_valid = 1'b0;
  logic [LW-1:0] ack_line = '0;
  logic [LW-1:0] rd_line = '0;
  logic req_valid, grant_valid, inv_ack_valid, busy;
  logic [1:0] req_kind;
  logic [LW-1:0] req_line, grant_line, inv_ack_line;
  logic [2:0] rd_state;
  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  coh_race_ctl #(.NUM_LINES(NL), .ID_W(2), .MY_ID(ME)) u_coh_race_ctl (
    .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_op(cpu_op), .cpu_line(cpu_line),
    .inv_valid(inv_valid), .inv_line(inv_line), .inv_owner(inv_owner),
    .ack_valid(ack_valid), .ack_line(ack_line), .rd_line(rd_line),
    .req_valid(req_valid), .req_kind(req_kind), .req_line(req_line),
    .grant_valid(grant_valid), .grant_line(grant_line),
    .inv_ack_valid(inv_ack_valid), .inv_ack_line(inv_ack_line),
    .busy(busy), .rd_state(rd_state));

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic state_is(string tag, int ln, int exp);
    rd_line = LW'(ln);
    step();
    chk(tag, int'(rd_state), exp);
  endtask

  task automatic cpu(int op, int ln, int exp_req, int exp_kind, int exp_grant, string tag);
    cpu_valid = 1'b1; cpu_op = 2'(op); cpu_line = LW'(ln);
    step();
    cpu_valid = 1'b0; cpu_op = 2'd3;
    chk({tag, " req"}, int'(req_valid), exp_req);
    if (exp_req == 1) begin
      chk({tag, " kind"}, int'(req_kind), exp_kind);
      chk({tag, " line"}, int'(req_line), ln);
    end
    chk({tag, " grant"}, int'(grant_valid), exp_grant);
  endtask

  task automatic inv(int ln, int owner);
    inv_valid = 1'b1; inv_line = LW'(ln); inv_owner = 2'(owner);
    step();
    inv_valid = 1'b0;
    chk("R10 inv ack", int'(inv_ack_valid), 1);
    chk("R10 inv ack line", int'(inv_ack_line), ln);
  endtask

  task automatic ack(int ln, int exp_grant, string tag);
    ack_valid = 1'b1; ack_line = LW'(ln);
    step();
    ack_valid = 1'b0;
    chk({tag, " grant"}, int'(grant_valid), exp_grant);
    if (exp_grant == 1) chk({tag, " grant line"}, int'(grant_line), ln);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      vectors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst = 1'b0;
    chk("R1 busy", int'(busy), 0);
    chk("R1 req", int'(req_valid), 0);
    chk("R1 grant", int'(grant_valid), 0);
    chk("R1 inv ack", int'(inv_ack_valid), 0);
    for (int l = 0; l < NL; l++) state_is("R1 state", l, 0);

    for (int l = 0; l < NL; l++) begin
      int other;
      other = (ME + 1 + l) % 4;
      if (other == ME) other = (other + 1) % 4;
      // fill and ignored refill
      cpu(0, l, 0, 0, 0, "R2 fill");
      state_is("R2 shared", l, 1);
      cpu(0, l, 0, 0, 0, "R2 refill");
      state_is("R2 refill ignored", l, 1);
      // upgrade
      cpu(1, l, 1, 0, 0, "R3 upgrade");
      chk("R3 busy", int'(busy), 1);
      state_is("R3 pending upgrade", l, 3);
      cpu(2, l, 0, 0, 0, "R11 busy evict");
      cpu(1, (l + 1) % NL, 0, 0, 0, "R11 busy write");
      state_is("R11 unchanged", l, 3);
      if (l % 2 == 0) begin
        inv(l, ME);
        state_is("R6 won race", l, 3);
        ack(l, 1, "R5 upgrade ack");
      end else begin
        inv(l, other);
        state_is("R7 lost race", l, 4);
        chk("R7 still busy", int'(busy), 1);
        ack(l, 1, "R7 write miss ack");
      end
      chk("R5 busy clear", int'(busy), 0);
      state_is("R5 modified", l, 2);
      cpu(1, l, 0, 0, 1, "R4 write on M");
      ack(l, 0, "R5 stray ack");
      state_is("R5 stray ignored", l, 2);
      // writeback racing an invalidate
      cpu(2, l, 1, 2, 0, "R8 evict M");
      state_is("R8 pending wb", l, 5);
      inv(l, other);
      state_is("R9 wb hold", l, 5);
      ack((l + 1) % NL, 0, "R5 wrong line ack");
      chk("R5 wrong line busy", int'(busy), 1);
      state_is("R5 wrong line state", l, 5);
      ack(l, 0, "R8 wb ack");
      state_is("R8 invalid after wb", l, 0);
      chk("R8 busy clear", int'(busy), 0);
      // write miss, then invalidate on M
      cpu(1, l, 1, 1, 0, "R4 write miss");
      state_is("R4 pending miss", l, 4);
      inv(l, other);
      state_is("R9 pwm unchanged", l, 4);
      ack(l, 1, "R5 miss ack");
      state_is("R5 miss to M", l, 2);
      inv(l, other);
      state_is("R9 M to I", l, 0);
      inv(l, ME);
      state_is("R9 I unchanged", l, 0);
      // silent evict of shared and invalidate on shared
      cpu(0, l, 0, 0, 0, "R2 fill again");
      cpu(2, l, 0, 0, 0, "R8 evict S");
      state_is("R8 silent evict", l, 0);
      cpu(0, l, 0, 0, 0, "R2 fill third");
      inv(l, other);
      state_is("R9 S to I", l, 0);
      // core op alongside invalidate
      cpu_valid = 1'b1; cpu_op = 2'd0; cpu_line = LW'(l);
      inv(( l + 1) % NL, other);
      cpu_valid = 1'b0; cpu_op = 2'd3;
      state_is("R11 op with inv", l, 0);
      // lookup latency
      rd_line = LW'(l);
      step();
      chk("R12 lookup", int'(rd_state), 0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule